// File: doc/BRIEF.md
# 32-Pin General-Purpose I/O Bank

This block controls one bank of 32 general-purpose pins through a small register bus with byte offsets, 32-bit data, and separate read and write strobes. Software picks each pin's direction with an active-low direction mask. It drives outputs through a data-out register, which can be written whole or changed through atomic set and clear aliases. It reads the pin levels after they pass through a two-stage synchronizer.

Each input pin has a rising-edge enable and a falling-edge enable. An enabled edge on a pin latches a sticky pending bit. Software clears a pending bit by writing a one to it. The pending bits are masked by an interrupt-enable register, and the result is ORed into one registered interrupt line. A fixed version word at offset 0x00 lets software confirm that the bank is present.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction mask (0x34) reads all ones, so every pin is an input. Data-out, both edge enables, interrupt enable and pending status all read zero, and `irq` is low.
- R2: Offset 0x00 always reads 0x00000025 (major 2 in bits 7:4, minor 5 in bits 3:0). Writes to it have no effect.
- R3: The direction register at 0x34 drives `pin_oe_n` bit for bit. A 0 marks that pin as an output and a 1 marks it as an input.
- R4: A write to 0x94 sets each data-out bit whose written bit is 1 and leaves every other bit unchanged.
- R5: A write to 0x90 clears each data-out bit whose written bit is 1 and leaves every other bit unchanged.
- R6: Offset 0x38 reads the pin levels after a two-flop synchronizer. Writes to it have no effect.
- R7: When a bit of the rising-edge enable (0x48) is set, a 0-to-1 change of that synchronized pin sets its pending bit at 0x18.
- R8: When a bit of the falling-edge enable (0x4C) is set, a 1-to-0 change of that synchronized pin sets its pending bit. An edge whose direction is not enabled sets nothing.
- R9: Pending bits stay set until software writes 1 to them at 0x18. Writing back a value just read clears exactly those bits, and pending bits written with 0 stay set.
- R10: `irq` is the registered OR of (pending AND enable at 0x1C) and follows one cycle after either register changes. Pending bits latch even when their enable bit is 0.
- R11: If an edge on a pin is detected in the same cycle as a write-1-to-clear of that pin's pending bit, the bit stays set.
- R12: Data-out (0x3C) is written directly, reads back its value and drives `pin_out`. `rdata` is registered and valid the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Output levels toward the pads |
| pin_oe_n | output | 32 | Per-pin drive enable, 0 = drive |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on the same pending bit in the same cycle: edge capture setting it and a software write clearing it. The bench first leaves a pin's bit pending. It then moves that pin at a known negative edge and counts the two synchronizer stages, so that the write-one-to-clear to 0x18 is sampled on exactly the edge that reports the new transition. The bit must still read as set afterwards. A clear issued on its own must then empty it, which shows that the write itself was accepted.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 8;

  // byte offsets decoded by software; their values are part of the contract
  localparam logic [ADDR_W-1:0] OFS_VERSION  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PENDING  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IRQ_MASK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_DIR_N    = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_LEVEL    = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_DRIVE    = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_RISE_EN  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_DRV_CLR  = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_DRV_SET  = 8'h94;

  localparam logic [3:0] VER_MAJOR = 4'd2;
  localparam logic [3:0] VER_MINOR = 4'd5;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] rise_en_i,
  input  logic [WIDTH-1:0] fall_en_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] ack_i,
  output logic [WIDTH-1:0] pending_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] last_q;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] pend_q;
  logic             irq_q;

  always_comb begin
    hit = (level_i & ~last_q & rise_en_i) | (~level_i & last_q & fall_en_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      last_q <= level_i;
      // a new edge beats a simultaneous acknowledge
      pend_q <= (pend_q & ~ack_i) | hit;
      irq_q  <= |(pend_q & mask_i);
    end
  end

  assign pending_o = pend_q;
  assign irq_o     = irq_q;

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend_q) & ~$past(ack_i) & ~pend_q) == '0)); // R9
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    ((hit & ack_i) != '0) |=> ((pend_q & $past(hit & ack_i)) == $past(hit & ack_i))); // R11
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == |($past(pend_q) & $past(mask_i)))); // R10
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS       = 32,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe_n,
  output logic              irq
);
  localparam logic [PINS-1:0] VERSION_WORD = {{(PINS-8){1'b0}}, VER_MAJOR, VER_MINOR};

  logic [PINS-1:0] dir_n_q, drive_q, rise_q, fall_q, mask_q;
  logic [PINS-1:0] level, pending, ack;
  logic [PINS-1:0] rdata_q;

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_in),
    .sync_o  (level)
  );

  assign ack = (wr_en && addr == OFS_PENDING) ? wdata : '0;

  gpio_event_unit #(.WIDTH(PINS)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .level_i   (level),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .mask_i    (mask_q),
    .ack_i     (ack),
    .pending_o (pending),
    .irq_o     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_n_q <= '1;
      drive_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      mask_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_DIR_N:    dir_n_q <= wdata;
        OFS_DRIVE:    drive_q <= wdata;
        OFS_DRV_SET:  drive_q <= drive_q | wdata;
        OFS_DRV_CLR:  drive_q <= drive_q & ~wdata;
        OFS_RISE_EN:  rise_q  <= wdata;
        OFS_FALL_EN:  fall_q  <= wdata;
        OFS_IRQ_MASK: mask_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (addr)
        OFS_VERSION:  rdata_q <= VERSION_WORD;
        OFS_PENDING:  rdata_q <= pending;
        OFS_IRQ_MASK: rdata_q <= mask_q;
        OFS_DIR_N:    rdata_q <= dir_n_q;
        OFS_LEVEL:    rdata_q <= level;
        OFS_DRIVE:    rdata_q <= drive_q;
        OFS_RISE_EN:  rdata_q <= rise_q;
        OFS_FALL_EN:  rdata_q <= fall_q;
        default:      rdata_q <= '0;
      endcase
    end
  end

  assign rdata    = rdata_q;
  assign pin_out  = drive_q;
  assign pin_oe_n = dir_n_q;

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DRV_SET) |=> ((drive_q & $past(wdata)) == $past(wdata))); // R4
  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DRV_CLR) |=> ((drive_q & $past(wdata)) == '0)); // R5
  AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_VERSION) |=> (rdata == 32'h0000_0025)); // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == OFS_DIR_N) |=> $stable(pin_oe_n)); // R3
endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe_n;
  logic        irq;
  int          n_cmp = 0, n_bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe_n(pin_oe_n), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 oe_n port", pin_oe_n, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h34, rv); chk("R1 dir reg", rv, 32'hFFFF_FFFF);
    rd(8'h3C, rv); chk("R1 drive reg", rv, 32'h0);
    rd(8'h18, rv); chk("R1 pending", rv, 32'h0);
    rd(8'h48, rv); chk("R1 rise en", rv, 32'h0);
    rd(8'h1C, rv); chk("R1 irq mask", rv, 32'h0);
  endtask

  task automatic t_version();
    rd(8'h00, rv); chk("R2 version", rv, 32'h25);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, rv); chk("R2 version after write", rv, 32'h25);
  endtask

  task automatic t_drive();
    wr(8'h3C, 32'hA5A5_0F0F);
    rd(8'h3C, rv); chk("R12 drive readback", rv, 32'hA5A5_0F0F);
    chk("R12 pin_out", pin_out, 32'hA5A5_0F0F);
    wr(8'h34, 32'hFFFF_0000);
    chk("R3 oe_n", pin_oe_n, 32'hFFFF_0000);
    wr(8'h94, 32'h0000_00F0);
    rd(8'h3C, rv); chk("R4 set alias", rv, 32'hA5A5_0FFF);
    wr(8'h90, 32'hA000_0001);
    rd(8'h3C, rv); chk("R5 clear alias", rv, 32'h05A5_0FFE);
    chk("R5 pin_out", pin_out, 32'h05A5_0FFE);
  endtask

  task automatic t_level();
    @(negedge clk); pin_in = 32'h1234_5678;
    settle();
    rd(8'h38, rv); chk("R6 level", rv, 32'h1234_5678);
    wr(8'h38, 32'h0);
    rd(8'h38, rv); chk("R6 level write ignored", rv, 32'h1234_5678);
    @(negedge clk); pin_in = 32'h0;
    settle();
  endtask

  task automatic t_rise();
    wr(8'h48, 32'h0000_0008);
    @(negedge clk); pin_in[3] = 1'b1;
    settle();
    rd(8'h18, rv); chk("R7 rise latched", rv, 32'h8);
    chk("R10 no irq while masked", {31'b0, irq}, 32'h0);
    wr(8'h1C, 32'h0000_0008);
    @(negedge clk);
    chk("R10 irq after mask", {31'b0, irq}, 32'h1);
    @(negedge clk); pin_in[3] = 1'b0;
    settle();
    rd(8'h18, rv); chk("R8 fall not enabled", rv, 32'h8);
    wr(8'h18, rv);
    rd(8'h18, rv); chk("R9 write-back clears", rv, 32'h0);
    chk("R10 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_fall();
    wr(8'h48, 32'h0000_1000);
    wr(8'h4C, 32'h0000_0080);
    @(negedge clk); pin_in[7] = 1'b1; pin_in[12] = 1'b1;
    settle();
    rd(8'h18, rv); chk("R7 rise bit12 only", rv, 32'h1000);
    @(negedge clk); pin_in[7] = 1'b0;
    settle();
    rd(8'h18, rv); chk("R8 fall latched", rv, 32'h1080);
    wr(8'h18, 32'h0000_0080);
    rd(8'h18, rv); chk("R9 partial clear", rv, 32'h1000);
    wr(8'h18, 32'h0000_1000);
    rd(8'h18, rv); chk("R9 cleared", rv, 32'h0);
  endtask

  task automatic t_collide();
    wr(8'h4C, 32'h0);
    wr(8'h48, 32'h0000_0020);
    @(negedge clk); pin_in[5] = 1'b1;
    settle();
    @(negedge clk); pin_in[5] = 1'b0;
    settle();
    rd(8'h18, rv); chk("R11 pre pending", rv, 32'h20);
    @(negedge clk); pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 8'h18; wdata = 32'h20;
    @(negedge clk); wr_en = 1'b0;
    rd(8'h18, rv); chk("R11 edge beats clear", rv, 32'h20);
    wr(8'h18, 32'h20);
    rd(8'h18, rv); chk("R11 lone clear works", rv, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_version();
    t_drive();
    t_level();
    t_rise();
    t_fall();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule